// File: doc/BRIEF.md
# Multi-Mode Microcontroller I/O Port

This block is a bank of per-pin configuration and data registers that a microcontroller reaches over a simple read/write bus. It sits behind one chip-select that decodes a 256-byte I/O window. The low address byte picks a register inside that window. Each of the eight pins can act in one of four roles. It can be a software-driven I/O pin, it can carry a latched address bit, it can carry a special-function output, or it can be handed to the programmable logic array. Per-pin register bits set the role, the direction, the driver style and the software output value.

The block produces a value and an output enable for every pad. It feeds the pad levels back through a two-flop synchronizer. It also returns the live pin levels, the output latch, the macrocell outputs and the pin ownership on read. The logic array and the address latch live elsewhere, and their signals enter as plain inputs. Read data appears on the cycle after the read strobe. On every other cycle the read bus rests at zero.

Top module: `pinModePort`

## Requirements
- R1: After reset the mode, direction, open-drain, special-function and output-latch registers read 0x00. Every pin that logic does not own has its output enable low.
- R2: A write lands only when `csIo` and `wrEn` are both high. The offsets are 0x00 mode, 0x01 direction, 0x02 open-drain, 0x03 special function and 0x06 output latch. A write with `csIo` low changes nothing.
- R3: A read with `csIo` and `rdEn` high returns its data on `rdData` one cycle later. Unmapped offsets (0x08 to 0xFF) return 0x00. `rdData` is 0x00 on any cycle that does not follow a read strobe.
- R4: On a pin with its special-function bit clear, a mode bit of 1 drives the output-latch bit. A mode bit of 0 drives the `addrBits` bit.
- R5: A direction bit of 1 enables the pad driver and 0 leaves the pin as an input. The direction register reads back at 0x01.
- R6: With its open-drain bit at 1, a pin drives low (`padOut`=0, `padOe`=direction) when its selected value is 0. It releases the pad (`padOe`=0) when that value is 1. With the bit at 0, the pin drives both levels.
- R7: A special-function bit of 1 makes the pin drive its `sfOut` bit, whatever its mode bit holds.
- R8: A pin whose `logicOwn` bit is 1 takes `padOut` from `logicOut` and `padOe` from `logicOe`, ahead of every register setting. Offset 0x04 reads `logicOwn`, and writes to it are ignored.
- R9: Offset 0x05 returns the pad levels after a two-flop synchronizer. A level applied to the pads two clock edges before the read strobe's edge is returned. A level applied after the previous edge is not yet returned.
- R10: Offset 0x07 returns the current `mcellOut`. Writes to 0x05 and 0x07 leave every register unchanged.
- R11: The output latch at 0x06 reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIo | input | 1 | Select for the 256-byte I/O window |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 8 | Register offset within the window |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid the cycle after the read strobe |
| padIn | input | 8 | Pad input levels (asynchronous) |
| addrBits | input | 8 | Latched address bits for address-out pins |
| sfOut | input | 8 | Special-function output per pin |
| logicOwn | input | 8 | 1 marks a pin owned by the logic array |
| logicOut | input | 8 | Logic array output value per pin |
| logicOe | input | 8 | Logic array output enable per pin |
| mcellOut | input | 8 | Macrocell output values |
| padOut | output | 8 | Pad output value |
| padOe | output | 8 | Pad output enable |

## Verification
Some pad rules are checked by the assertions on every cycle. An open-drain pin never drives high, and a logic-owned pin always mirrors the logic array. A non-owned pin with direction 0 never drives. The read bus rests at zero between reads, and at most one write strobe fires at a time. The bench scenarios show the rest: the mode priority across mixed per-pin patterns, the exact read latency and the synchronizer depth. They also show that writes outside the chip-select or to read-only offsets are dropped, which only reading the registers back can reveal.

// File: rtl/pinModePkg.sv
package pinModePkg;
  localparam int unsigned OFF_CTL  = 0;
  localparam int unsigned OFF_DIR  = 1;
  localparam int unsigned OFF_OD   = 2;
  localparam int unsigned OFF_SF   = 3;
  localparam int unsigned OFF_OWN  = 4;
  localparam int unsigned OFF_DIN  = 5;
  localparam int unsigned OFF_DOUT = 6;
  localparam int unsigned OFF_MC   = 7;
  localparam int unsigned SEL_W    = 3;

  typedef struct packed {
    logic             wrCtl;
    logic             wrDir;
    logic             wrOd;
    logic             wrSf;
    logic             wrDout;
    logic             rdHit;
    logic [SEL_W-1:0] rdSel;
  } portStrobe_t;
endpackage

// File: rtl/pinModeCtrl.sv
module pinModeCtrl
  import pinModePkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIo,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output portStrobe_t       strb
);
  localparam int unsigned HI_W = ADDR_W - SEL_W;

  logic             inMap;
  logic             doWr;
  logic [SEL_W-1:0] off;

  assign off   = addr[SEL_W-1:0];
  assign inMap = (addr[ADDR_W-1:SEL_W] == {HI_W{1'b0}});
  assign doWr  = csIo && wrEn && inMap;

  always_comb begin
    strb        = '0;
    strb.wrCtl  = doWr && (off == SEL_W'(OFF_CTL));
    strb.wrDir  = doWr && (off == SEL_W'(OFF_DIR));
    strb.wrOd   = doWr && (off == SEL_W'(OFF_OD));
    strb.wrSf   = doWr && (off == SEL_W'(OFF_SF));
    strb.wrDout = doWr && (off == SEL_W'(OFF_DOUT));
    strb.rdHit  = csIo && rdEn && inMap;
    strb.rdSel  = off;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtl, strb.wrDir, strb.wrOd, strb.wrSf, strb.wrDout})); // R2
  AST_NO_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !csIo |-> !(strb.wrCtl || strb.wrDir || strb.wrOd || strb.wrSf || strb.wrDout)); // R2
endmodule

// File: rtl/pinModeDatapath.sv
module pinModeDatapath
  import pinModePkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strb,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] padIn,
  input  logic [PIN_W-1:0] addrBits,
  input  logic [PIN_W-1:0] sfOut,
  input  logic [PIN_W-1:0] logicOwn,
  input  logic [PIN_W-1:0] logicOut,
  input  logic [PIN_W-1:0] logicOe,
  input  logic [PIN_W-1:0] mcellOut,
  output logic [PIN_W-1:0] rdData,
  output logic [PIN_W-1:0] padOut,
  output logic [PIN_W-1:0] padOe
);
  logic [PIN_W-1:0] ctlReg, dirReg, odReg, sfReg, doutReg;
  logic [PIN_W-1:0] syncA, syncB;
  logic [PIN_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg  <= '0;
      dirReg  <= '0;
      odReg   <= '0;
      sfReg   <= '0;
      doutReg <= '0;
      syncA   <= '0;
      syncB   <= '0;
      rdData  <= '0;
    end else begin
      if (strb.wrCtl)  ctlReg  <= wrData;
      if (strb.wrDir)  dirReg  <= wrData;
      if (strb.wrOd)   odReg   <= wrData;
      if (strb.wrSf)   sfReg   <= wrData;
      if (strb.wrDout) doutReg <= wrData;
      syncA  <= padIn;
      syncB  <= syncA;
      rdData <= rdNext;
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdHit) begin
      case (strb.rdSel)
        SEL_W'(OFF_CTL):  rdNext = ctlReg;
        SEL_W'(OFF_DIR):  rdNext = dirReg;
        SEL_W'(OFF_OD):   rdNext = odReg;
        SEL_W'(OFF_SF):   rdNext = sfReg;
        SEL_W'(OFF_OWN):  rdNext = logicOwn;
        SEL_W'(OFF_DIN):  rdNext = syncB;
        SEL_W'(OFF_DOUT): rdNext = doutReg;
        default:          rdNext = mcellOut;
      endcase
    end
  end

  for (genvar i = 0; i < PIN_W; i++) begin : gPin
    logic srcVal;
    assign srcVal    = sfReg[i] ? sfOut[i] : (ctlReg[i] ? doutReg[i] : addrBits[i]);
    assign padOut[i] = logicOwn[i] ? logicOut[i] : (odReg[i] ? 1'b0 : srcVal);
    assign padOe[i]  = logicOwn[i] ? logicOe[i]  : (dirReg[i] & ~(odReg[i] & srcVal));
  end

  AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOut & odReg & ~logicOwn) == '0); // R6
  AST_OWN_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut ^ logicOut) & logicOwn) == '0 && ((padOe ^ logicOe) & logicOwn) == '0); // R8
  AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~logicOwn & ~dirReg) == '0); // R5
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdHit |=> rdData == '0); // R3
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDout |=> $stable(doutReg)); // R11
endmodule

// File: rtl/pinModePort.sv
module pinModePort
  import pinModePkg::*;
#(
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIo,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wrData,
  output logic [PIN_W-1:0]  rdData,
  input  logic [PIN_W-1:0]  padIn,
  input  logic [PIN_W-1:0]  addrBits,
  input  logic [PIN_W-1:0]  sfOut,
  input  logic [PIN_W-1:0]  logicOwn,
  input  logic [PIN_W-1:0]  logicOut,
  input  logic [PIN_W-1:0]  logicOe,
  input  logic [PIN_W-1:0]  mcellOut,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padOe
);
  portStrobe_t strb;

  pinModeCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csIo(csIo), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .strb(strb)
  );

  pinModeDatapath #(.PIN_W(PIN_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .padIn(padIn),
    .addrBits(addrBits), .sfOut(sfOut), .logicOwn(logicOwn),
    .logicOut(logicOut), .logicOe(logicOe), .mcellOut(mcellOut),
    .rdData(rdData), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/sim_pinModePort.sv
module sim_pinModePort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIo = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] addr = '0, wrData = '0;
  logic [7:0] padIn = '0, addrBits = '0, sfOut = '0;
  logic [7:0] logicOwn = '0, logicOut = '0, logicOe = '0, mcellOut = '0;
  logic [7:0] rdData, padOut, padOe;
  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] got;

  always #2 clk = ~clk;

  pinModePort u0 (
    .clk(clk), .rstN(rstN), .csIo(csIo), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .padIn(padIn),
    .addrBits(addrBits), .sfOut(sfOut), .logicOwn(logicOwn),
    .logicOut(logicOut), .logicOe(logicOe), .mcellOut(mcellOut),
    .padOut(padOut), .padOe(padOe)
  );

  // ctl dir od sf dout addr sfo own lo loe | expOut expOe
  localparam logic [95:0] VEC [7] = '{
    {8'hFF,8'hFF,8'h00,8'h00,8'hA5,8'h3C,8'h0F,8'h00,8'h00,8'h00, 8'hA5,8'hFF}, // R4 latch
    {8'h00,8'hFF,8'h00,8'h00,8'hA5,8'h3C,8'h0F,8'h00,8'h00,8'h00, 8'h3C,8'hFF}, // R4 address
    {8'hF0,8'h0F,8'h00,8'h00,8'hA5,8'h3C,8'h0F,8'h00,8'h00,8'h00, 8'hAC,8'h0F}, // R4 R5 mixed
    {8'hFF,8'hFF,8'h00,8'hC3,8'hA5,8'h3C,8'h0F,8'h00,8'h00,8'h00, 8'h27,8'hFF}, // R7
    {8'hFF,8'hFF,8'hFF,8'h00,8'hA5,8'h3C,8'h0F,8'h00,8'h00,8'h00, 8'h00,8'h5A}, // R6
    {8'hFF,8'h00,8'hFF,8'h00,8'hA5,8'h3C,8'h0F,8'hF0,8'h5A,8'h3C, 8'h50,8'h30}, // R8
    {8'h00,8'hFF,8'h0F,8'h00,8'hA5,8'h3C,8'h0F,8'h00,8'h00,8'h00, 8'h30,8'hF3}  // R6 mixed
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    csIo = sel; wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    csIo = 1'b0; wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    csIo = 1'b1; rdEn = 1'b1; addr = a;
    @(negedge clk);
    d = rdData;
    csIo = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    check("R3 idle rdData", rdData, 8'h00);
    for (int k = 0; k < 4; k++) begin
      busRead(8'(k), got); check("R1 reg", got, 8'h00);
    end
    busRead(8'h06, got); check("R1 dout", got, 8'h00);

    // Vector table
    for (int v = 0; v < 7; v++) begin
      logic [95:0] e;
      e = VEC[v];
      addrBits = e[55:48]; sfOut = e[47:40];
      logicOwn = e[39:32]; logicOut = e[31:24]; logicOe = e[23:16];
      busWrite(8'h00, e[95:88], 1'b1);
      busWrite(8'h01, e[87:80], 1'b1);
      busWrite(8'h02, e[79:72], 1'b1);
      busWrite(8'h03, e[71:64], 1'b1);
      busWrite(8'h06, e[63:56], 1'b1);
      @(negedge clk);
      check("R4-R8 padOut", padOut, e[15:8]);
      check("R4-R8 padOe", padOe, e[7:0]);
    end

    // R5 direction readback, R11 latch readback
    busWrite(8'h01, 8'h6B, 1'b1);
    busRead(8'h01, got); check("R5 dir readback", got, 8'h6B);
    busWrite(8'h06, 8'h9E, 1'b1);
    busRead(8'h06, got); check("R11 dout readback", got, 8'h9E);

    // R2 write without chip-select dropped
    busWrite(8'h06, 8'h11, 1'b0);
    busRead(8'h06, got); check("R2 no-cs write", got, 8'h9E);
    // R2 write to mirrored high address dropped
    busWrite(8'h16, 8'h22, 1'b1);
    busRead(8'h06, got); check("R2 unmapped write", got, 8'h9E);

    // R8 ownership readback, write ignored
    logicOwn = 8'hC5;
    busWrite(8'h04, 8'h00, 1'b1);
    busRead(8'h04, got); check("R8 own read", got, 8'hC5);

    // R10 macrocell and read-only writes
    mcellOut = 8'h7D;
    busRead(8'h07, got); check("R10 mcell", got, 8'h7D);
    busWrite(8'h05, 8'h00, 1'b1);
    busWrite(8'h07, 8'h00, 1'b1);
    busRead(8'h06, got); check("R10 ro write dout", got, 8'h9E);
    busRead(8'h01, got); check("R10 ro write dir", got, 8'h6B);

    // R3 unmapped read and idle bus
    busRead(8'h09, got); check("R3 unmapped read", got, 8'h00);
    @(negedge clk);
    check("R3 idle after read", rdData, 8'h00);

    // R9 synchronizer depth
    @(negedge clk); padIn = 8'h3A;
    repeat (3) @(negedge clk);
    padIn = 8'hC4;
    busRead(8'h05, got); check("R9 early read old", got, 8'h3A);
    @(negedge clk); padIn = 8'h96;
    @(negedge clk);
    busRead(8'h05, got); check("R9 after two edges", got, 8'h96);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    logicOwn = 8'h00;
    @(negedge clk);
    check("R1 re-reset padOe", padOe, 8'h00);
    busRead(8'h06, got); check("R1 re-reset dout", got, 8'h00);
    busRead(8'h01, got); check("R1 re-reset dir", got, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule